// File: doc/BRIEF.md
# Segment Address Translation Unit

This block converts a segment-relative memory access into a linear address. It keeps six segment selector registers and a small store of segment descriptors. Each descriptor holds a base, an inclusive limit and read, write and execute permission bits. The store is divided into a global table and a local table. Each table is placed inside the store by its own register, which gives a starting slot and an entry count.

On each request the block picks a selector. The access type decides the default: instruction fetches go through the code selector, stack accesses through the stack selector, and ordinary loads and stores through the data selector. An explicit override can name any of the six selectors instead, and the three extra selectors are reachable only that way.

The block then checks the request in a fixed order:
- the requested selector number,
- the selector's ring field against the caller's ring,
- the null descriptor,
- the table bounds,
- the permissions,
- the segment limit.

If every check passes, the block forms the linear address as base plus offset. The response is registered one cycle after the request. All tables and selectors are loaded through one configuration write port, and only ring 0 may use it. A descriptor with base 0 and an all-ones limit makes translation a pass-through.

Top module: `seg_xlate`

## Requirements
- R1: Every cycle with `req_valid` high produces `rsp_valid` high on the next clock edge. With no request, `rsp_valid`, `rsp_fault`, `rsp_code` and `rsp_lin` are all 0 on the next edge.
- R2: Selector choice and override values:
  - Selector numbers are 0 code, 1 data, 2 stack, 3 to 5 extra.
  - Without an override, `req_kind` 0 (fetch) uses selector 0, 1 (stack) uses selector 2, and 2 or 3 (data) uses selector 1.
  - With `req_ovr_en` high, `req_ovr_seg` names the selector.
  - An override value of 6 or 7 faults with code 1.
- R3: A selector holds its descriptor index in bits [15:3], its table flag in bit [2] (0 global, 1 local) and its ring in bits [1:0]. If `req_ring` is numerically greater than the selector's ring, the access faults with code 2.
- R4: A selector with table flag 0 and index 0 refers to the null descriptor. Any access through it faults with code 3, whatever the tables hold.
- R5: The descriptor slot is the table's start slot plus the index, wrapping modulo the store depth. If the index is not below the table's entry count, the access faults with code 4.
- R6: Descriptor permission bits are [0] read, [1] write, [2] execute. The access faults with code 5 in any of these cases:
  - a fetch from a descriptor without execute,
  - a non-fetch write to a descriptor without write,
  - a non-fetch read from a descriptor without read.
- R7: An offset greater than the descriptor limit faults with code 6. The limit itself is a legal offset.
- R8: A fault-free access returns `rsp_fault`=0, `rsp_code`=0 and `rsp_lin` = base + offset modulo 2^AW. With base 0 and an all-ones limit, `rsp_lin` equals the offset.
- R9: A faulting access returns `rsp_fault`=1 and `rsp_lin`=0. When several checks fail, the lowest code (1 to 6) is reported.
- R10: Configuration writes (`cfg_we`) take effect on the next edge and are ignored unless `cfg_ring` is 0. The `cfg_tgt` encodings are:
  - 0 writes descriptor slot `cfg_idx`.
  - 1 writes the table register chosen by `cfg_idx[0]` (0 global, 1 local). The start slot comes from the low SLOT_W bits of `cfg_base` and the entry count from the low SLOT_W+1 bits of `cfg_limit`.
  - 2 writes selector `cfg_idx[2:0]` with `cfg_sel`.
  - 3 does nothing.
- R11: After reset, every selector is 0 and both table counts are 0. A ring 0 access then faults with code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ring | input | 2 | Ring of the configuration writer |
| cfg_tgt | input | 2 | Write target: descriptor, table register, selector |
| cfg_idx | input | SLOT_W | Slot, table or selector number |
| cfg_base | input | AW | Descriptor base, or table start slot |
| cfg_limit | input | AW | Descriptor limit, or table entry count |
| cfg_perm | input | 3 | Descriptor permission bits |
| cfg_sel | input | 16 | Selector value |
| req_valid | input | 1 | Translation request |
| req_kind | input | 2 | Access type: 0 fetch, 1 stack, 2/3 data |
| req_write | input | 1 | Non-fetch access is a write |
| req_ovr_en | input | 1 | Use the override selector |
| req_ovr_seg | input | 3 | Override selector number |
| req_ofs | input | AW | Segment offset |
| req_ring | input | 2 | Current privilege ring |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Request faulted |
| rsp_code | output | 3 | Fault reason, 0 when none |
| rsp_lin | output | AW | Linear address, 0 on a fault |

## Verification
The assertions assume the block sees a clean reset before its first request. Configuration writes and requests may fall in the same cycle, but a request then sees the state from before the write. The bench never issues both in one cycle, so its reference tables always match the state the design translates against. Every one of the 16 descriptor slots is written before any table can reach it, so random table registers cannot select an unwritten slot.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int SEL_W  = 16;
  localparam int IDX_W  = 13;
  localparam int NSEG   = 6;

  localparam logic [2:0] SEG_CODE  = 3'd0;
  localparam logic [2:0] SEG_DATA  = 3'd1;
  localparam logic [2:0] SEG_STACK = 3'd2;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_STACK = 2'd1;

  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;

  localparam logic [1:0] TGT_DESC = 2'd0;
  localparam logic [1:0] TGT_TBL  = 2'd1;
  localparam logic [1:0] TGT_SEL  = 2'd2;

  localparam logic [2:0] FLT_NONE   = 3'd0;
  localparam logic [2:0] FLT_BADSEG = 3'd1;
  localparam logic [2:0] FLT_PRIV   = 3'd2;
  localparam logic [2:0] FLT_NULL   = 3'd3;
  localparam logic [2:0] FLT_RANGE  = 3'd4;
  localparam logic [2:0] FLT_PERM   = 3'd5;
  localparam logic [2:0] FLT_LIMIT  = 3'd6;

  function automatic logic [IDX_W-1:0] sel_index(input logic [SEL_W-1:0] s);
    return s[SEL_W-1:3];
  endfunction

  function automatic logic sel_is_local(input logic [SEL_W-1:0] s);
    return s[2];
  endfunction

  function automatic logic [1:0] sel_ring(input logic [SEL_W-1:0] s);
    return s[1:0];
  endfunction
endpackage

// File: rtl/seg_sel_file.sv
module seg_sel_file
  import seg_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_seg,
  input  logic [SEL_W-1:0] wr_val,
  input  logic [1:0]       kind,
  input  logic             ovr_en,
  input  logic [2:0]       ovr_seg,
  output logic [SEL_W-1:0] sel,
  output logic             bad_seg
);
  logic [SEL_W-1:0] regs [NSEG];
  logic [2:0]       pick;

  for (genvar g = 0; g < NSEG; g++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst) regs[g] <= '0;
      else if (wr_en && wr_seg == 3'(g)) regs[g] <= wr_val;
    end
  end

  always_comb begin
    if (ovr_en)                  pick = ovr_seg;
    else if (kind == KIND_FETCH) pick = SEG_CODE;
    else if (kind == KIND_STACK) pick = SEG_STACK;
    else                         pick = SEG_DATA;
  end

  always_comb begin
    bad_seg = (pick >= 3'(NSEG));
    sel     = '0;
    for (int i = 0; i < NSEG; i++)
      if (pick == 3'(i)) sel = regs[i];
  end
endmodule

// File: rtl/seg_desc_store.sv
module seg_desc_store
  import seg_xlate_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_we,
  input  logic [SLOT_W-1:0] desc_slot,
  input  logic [AW-1:0]     desc_base,
  input  logic [AW-1:0]     desc_limit,
  input  logic [2:0]        desc_perm,
  input  logic              tbl_we,
  input  logic              tbl_local,
  input  logic [SLOT_W-1:0] tbl_start,
  input  logic [SLOT_W:0]   tbl_count,
  input  logic              lk_local,
  input  logic [IDX_W-1:0]  lk_index,
  output logic              lk_in_range,
  output logic [AW-1:0]     lk_base,
  output logic [AW-1:0]     lk_limit,
  output logic [2:0]        lk_perm
);
  localparam int DEPTH = 1 << SLOT_W;
  localparam int DW    = 2 * AW + 3;
  localparam int CNT_W = SLOT_W + 1;

  logic [DW-1:0]     mem [DEPTH];
  logic [SLOT_W-1:0] t_start [2];
  logic [CNT_W-1:0]  t_count [2];
  logic [SLOT_W-1:0] rd_slot;
  logic [DW-1:0]     rd_word;
  logic              tsel;

  // Descriptor store: write-only port plus asynchronous read (distributed RAM).
  always_ff @(posedge clk) begin
    if (desc_we) mem[desc_slot] <= {desc_perm, desc_limit, desc_base};
  end

  for (genvar t = 0; t < 2; t++) begin : g_tbl
    always_ff @(posedge clk) begin
      if (rst) begin
        t_start[t] <= '0;
        t_count[t] <= '0;
      end else if (tbl_we && tbl_local == (t == 1)) begin
        t_start[t] <= tbl_start;
        t_count[t] <= tbl_count;
      end
    end
  end

  assign tsel        = lk_local;
  assign rd_slot     = t_start[tsel] + lk_index[SLOT_W-1:0];
  assign rd_word     = mem[rd_slot];
  assign lk_in_range = 32'(lk_index) < 32'(t_count[tsel]);
  assign lk_base     = rd_word[AW-1:0];
  assign lk_limit    = rd_word[2*AW-1:AW];
  assign lk_perm     = rd_word[DW-1:2*AW];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             bad_seg,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       ring,
  input  logic [1:0]       kind,
  input  logic             write,
  input  logic             in_range,
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    limit,
  input  logic [2:0]       perm,
  input  logic [AW-1:0]    ofs,
  output logic [2:0]       code,
  output logic [AW-1:0]    lin
);
  logic perm_bad;

  always_comb begin
    if (kind == KIND_FETCH) perm_bad = !perm[PERM_EX];
    else if (write)         perm_bad = !perm[PERM_WR];
    else                    perm_bad = !perm[PERM_RD];
  end

  always_comb begin
    if (bad_seg)                                       code = FLT_BADSEG;
    else if (ring > sel_ring(sel))                     code = FLT_PRIV;
    else if (!sel_is_local(sel) && sel_index(sel) == '0) code = FLT_NULL;
    else if (!in_range)                                code = FLT_RANGE;
    else if (perm_bad)                                 code = FLT_PERM;
    else if (ofs > limit)                              code = FLT_LIMIT;
    else                                               code = FLT_NONE;
  end

  assign lin = (code == FLT_NONE) ? base + ofs : '0;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int AW     = 32,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_ring,
  input  logic [1:0]        cfg_tgt,
  input  logic [SLOT_W-1:0] cfg_idx,
  input  logic [AW-1:0]     cfg_base,
  input  logic [AW-1:0]     cfg_limit,
  input  logic [2:0]        cfg_perm,
  input  logic [15:0]       cfg_sel,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_write,
  input  logic              req_ovr_en,
  input  logic [2:0]        req_ovr_seg,
  input  logic [AW-1:0]     req_ofs,
  input  logic [1:0]        req_ring,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [2:0]        rsp_code,
  output logic [AW-1:0]     rsp_lin
);
  localparam int CNT_W = SLOT_W + 1;

  logic             priv_we;
  logic [SEL_W-1:0] cur_sel;
  logic             bad_seg;
  logic             in_range;
  logic [AW-1:0]    d_base, d_limit;
  logic [2:0]       d_perm;
  logic [2:0]       code_c;
  logic [AW-1:0]    lin_c;

  // R10: only ring 0 may change translation state
  assign priv_we = cfg_we && (cfg_ring == 2'd0);

  seg_sel_file u_sel (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (priv_we && cfg_tgt == TGT_SEL),
    .wr_seg  (cfg_idx[2:0]),
    .wr_val  (cfg_sel),
    .kind    (req_kind),
    .ovr_en  (req_ovr_en),
    .ovr_seg (req_ovr_seg),
    .sel     (cur_sel),
    .bad_seg (bad_seg)
  );

  seg_desc_store #(.AW(AW), .SLOT_W(SLOT_W)) u_store (
    .clk         (clk),
    .rst         (rst),
    .desc_we     (priv_we && cfg_tgt == TGT_DESC),
    .desc_slot   (cfg_idx),
    .desc_base   (cfg_base),
    .desc_limit  (cfg_limit),
    .desc_perm   (cfg_perm),
    .tbl_we      (priv_we && cfg_tgt == TGT_TBL),
    .tbl_local   (cfg_idx[0]),
    .tbl_start   (cfg_base[SLOT_W-1:0]),
    .tbl_count   (cfg_limit[CNT_W-1:0]),
    .lk_local    (sel_is_local(cur_sel)),
    .lk_index    (sel_index(cur_sel)),
    .lk_in_range (in_range),
    .lk_base     (d_base),
    .lk_limit    (d_limit),
    .lk_perm     (d_perm)
  );

  seg_check #(.AW(AW)) u_chk (
    .bad_seg  (bad_seg),
    .sel      (cur_sel),
    .ring     (req_ring),
    .kind     (req_kind),
    .write    (req_write),
    .in_range (in_range),
    .base     (d_base),
    .limit    (d_limit),
    .perm     (d_perm),
    .ofs      (req_ofs),
    .code     (code_c),
    .lin      (lin_c)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_code  <= FLT_NONE;
      rsp_lin   <= '0;
    end else begin
      rsp_valid <= 1'b1;
      rsp_fault <= (code_c != FLT_NONE);
      rsp_code  <= code_c;
      rsp_lin   <= lin_c;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ovr_en,
  input logic [2:0]    req_ovr_seg,
  input logic          rsp_valid,
  input logic          rsp_fault,
  input logic [2:0]    rsp_code,
  input logic [AW-1:0] rsp_lin
);
  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_unasked_rsp_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_fault && rsp_code == 3'd0));

  assert_bad_override_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ovr_en && req_ovr_seg > 3'd5) |=> (rsp_fault && rsp_code == 3'd1));

  assert_fault_no_addr_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> rsp_lin == '0);

  assert_flag_matches_code_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault == (rsp_code != 3'd0)));

  assert_code_known_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_code <= 3'd6);
endmodule

bind seg_xlate seg_xlate_chk #(.AW(AW)) u_seg_xlate_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ovr_en  (req_ovr_en),
  .req_ovr_seg (req_ovr_seg),
  .rsp_valid   (rsp_valid),
  .rsp_fault   (rsp_fault),
  .rsp_code    (rsp_code),
  .rsp_lin     (rsp_lin)
);

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;
  localparam int AW = 32;
  localparam int SLOT_W = 4;

  logic clk = 0, rst = 1;
  logic cfg_we = 0;
  logic [1:0] cfg_ring = 0, cfg_tgt = 0;
  logic [SLOT_W-1:0] cfg_idx = 0;
  logic [AW-1:0] cfg_base = 0, cfg_limit = 0;
  logic [2:0] cfg_perm = 0;
  logic [15:0] cfg_sel = 0;
  logic req_valid = 0, req_write = 0, req_ovr_en = 0;
  logic [1:0] req_kind = 0, req_ring = 0;
  logic [2:0] req_ovr_seg = 0;
  logic [AW-1:0] req_ofs = 0;
  logic rsp_valid, rsp_fault;
  logic [2:0] rsp_code;
  logic [AW-1:0] rsp_lin;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench reference state
  logic [31:0] m_base [16];
  logic [31:0] m_lim  [16];
  logic [2:0]  m_perm [16];
  logic [3:0]  m_ts   [2];
  logic [4:0]  m_tc   [2];
  logic [15:0] m_sel  [6];

  always #5 clk = ~clk;

  seg_xlate #(.AW(AW), .SLOT_W(SLOT_W)) dut_i (.*);

  function automatic logic [34:0] model(input logic [1:0] kind, input logic wr,
      input logic oe, input logic [2:0] os, input logic [31:0] ofs, input logic [1:0] ring);
    logic [2:0] seg;
    logic [15:0] s;
    logic [12:0] idx;
    logic loc;
    logic [3:0] slot;
    logic pbad;
    seg = oe ? os : (kind == 2'd0 ? 3'd0 : (kind == 2'd1 ? 3'd2 : 3'd1));
    if (seg > 3'd5) return {3'd1, 32'd0};
    s = m_sel[seg];
    idx = s[15:3]; loc = s[2];
    if (ring > s[1:0]) return {3'd2, 32'd0};
    if (!loc && idx == 0) return {3'd3, 32'd0};
    if (32'(idx) >= 32'(m_tc[loc])) return {3'd4, 32'd0};
    slot = m_ts[loc] + idx[3:0];
    if (kind == 2'd0) pbad = !m_perm[slot][2];
    else if (wr) pbad = !m_perm[slot][1];
    else pbad = !m_perm[slot][0];
    if (pbad) return {3'd5, 32'd0};
    if (ofs > m_lim[slot]) return {3'd6, 32'd0};
    return {3'd0, m_base[slot] + ofs};
  endfunction

  task automatic cfg(input logic [1:0] ring, input logic [1:0] tgt, input logic [3:0] idx,
                     input logic [31:0] b, input logic [31:0] l, input logic [2:0] p, input logic [15:0] s);
    @(negedge clk);
    cfg_we = 1; cfg_ring = ring; cfg_tgt = tgt; cfg_idx = idx;
    cfg_base = b; cfg_limit = l; cfg_perm = p; cfg_sel = s;
    @(negedge clk);
    cfg_we = 0;
    if (ring == 0) begin
      case (tgt)
        2'd0: begin m_base[idx] = b; m_lim[idx] = l; m_perm[idx] = p; end
        2'd1: begin m_ts[idx[0]] = b[3:0]; m_tc[idx[0]] = l[4:0]; end
        2'd2: if (idx[2:0] < 3'd6) m_sel[idx[2:0]] = s;
        default: ;
      endcase
    end
  endtask

  task automatic xreq(input string tag, input logic [1:0] kind, input logic wr, input logic oe,
                      input logic [2:0] os, input logic [31:0] ofs, input logic [1:0] ring);
    logic [34:0] e;
    e = model(kind, wr, oe, os, ofs, ring);
    @(negedge clk);
    req_valid = 1; req_kind = kind; req_write = wr; req_ovr_en = oe;
    req_ovr_seg = os; req_ofs = ofs; req_ring = ring;
    @(negedge clk);
    req_valid = 0;
    checks++;
    if (rsp_valid !== 1'b1 || rsp_code !== e[34:32] || rsp_lin !== e[31:0] ||
        rsp_fault !== (e[34:32] != 0)) begin
      fails++;
      $display("FAIL %s: got v=%0b f=%0b code=%0d lin=%h, expected v=1 f=%0b code=%0d lin=%h",
               tag, rsp_valid, rsp_fault, rsp_code, rsp_lin, (e[34:32] != 0), e[34:32], e[31:0]);
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_fault !== 0 || rsp_code !== 0) begin
      fails++;
      $display("FAIL R1 idle: got v=%0b f=%0b code=%0d, expected 0 0 0", rsp_valid, rsp_fault, rsp_code);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lims [4];
    void'($urandom(32'd4321));
    for (int i = 0; i < 6; i++) m_sel[i] = 0;
    for (int i = 0; i < 2; i++) begin m_ts[i] = 0; m_tc[i] = 0; end
    for (int i = 0; i < 16; i++) begin m_base[i] = 0; m_lim[i] = 0; m_perm[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 0;
    idle_check();
    // R11: reset selectors point at null descriptor
    xreq("R11 reset null", 2'd2, 0, 0, 0, 32'h10, 2'd0);
    xreq("R3 reset ring", 2'd2, 0, 0, 0, 32'h10, 2'd3);

    lims[0] = 32'hFF; lims[1] = 32'h1FFF; lims[2] = 32'hFFFF_FFFF; lims[3] = 32'h0;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] lr;
      lr = lims[$urandom % 4];
      if (lr == 0) lr = $urandom & 32'hFFF;
      cfg(0, 0, 4'(i), $urandom, lr, 3'($urandom), 0);
    end
    cfg(0, 0, 4'd1, 32'h0, 32'hFFFF_FFFF, 3'b111, 0);
    cfg(0, 0, 4'd2, 32'h1000, 32'hFF, 3'b001, 0);
    cfg(0, 0, 4'd3, 32'h2000, 32'hFFF, 3'b100, 0);
    cfg(0, 0, 4'd9, 32'hFFFF_F000, 32'h1FFF, 3'b011, 0);
    cfg(0, 1, 4'd0, 32'd0, 32'd6, 0, 0);
    cfg(0, 1, 4'd1, 32'd8, 32'd5, 0, 0);
    cfg(0, 2, 4'd0, 0, 0, 0, 16'h0018);
    cfg(0, 2, 4'd1, 0, 0, 0, 16'h000B);
    cfg(0, 2, 4'd2, 0, 0, 0, 16'h0013);
    cfg(0, 2, 4'd3, 0, 0, 0, 16'h000F);
    cfg(0, 2, 4'd4, 0, 0, 0, 16'h003F);
    cfg(0, 2, 4'd5, 0, 0, 0, 16'h0003);

    xreq("R2 R8 fetch via code", 2'd0, 0, 0, 0, 32'h10, 2'd0);
    xreq("R3 fetch ring above selector", 2'd0, 0, 0, 0, 32'h10, 2'd1);
    xreq("R8 flat pass-through", 2'd2, 1, 0, 0, 32'hFFFF_FFFF, 2'd3);
    xreq("R6 stack write to read-only", 2'd1, 1, 0, 0, 32'h4, 2'd3);
    xreq("R7 offset at limit", 2'd1, 0, 0, 0, 32'hFF, 2'd3);
    xreq("R7 offset past limit", 2'd1, 0, 0, 0, 32'h100, 2'd3);
    xreq("R9 perm beats limit", 2'd1, 1, 0, 0, 32'h100, 2'd3);
    xreq("R8 R5 local wrap sum", 2'd2, 0, 1, 3'd3, 32'h1FFF, 2'd3);
    xreq("R5 index out of table", 2'd2, 0, 1, 3'd4, 32'h0, 2'd3);
    xreq("R4 null via extra", 2'd2, 0, 1, 3'd5, 32'h0, 2'd3);
    xreq("R2 override value 6", 2'd0, 0, 1, 3'd6, 32'h0, 2'd0);
    xreq("R2 override value 7", 2'd2, 1, 1, 3'd7, 32'h0, 2'd0);
    xreq("R6 fetch from non-exec", 2'd0, 0, 1, 3'd2, 32'h0, 2'd0);
    xreq("R6 data read of exec-only", 2'd3, 0, 1, 3'd0, 32'h0, 2'd0);
    idle_check();
    // R10: unprivileged write and unused target leave the code selector alone
    cfg(2'd1, 2, 4'd0, 0, 0, 0, 16'h0008);
    cfg(2'd0, 3, 4'd0, 0, 0, 0, 16'h0008);
    xreq("R10 ignored writes", 2'd0, 0, 0, 0, 32'h20, 2'd0);
    cfg(2'd0, 2, 4'd0, 0, 0, 0, 16'h0008);
    xreq("R10 privileged write applies", 2'd0, 0, 0, 0, 32'h20, 2'd0);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] o;
      if ($urandom % 16 == 0)
        cfg(2'($urandom % 3 == 0 ? $urandom : 0), 2'($urandom), 4'($urandom),
            ($urandom % 2) ? $urandom : 32'($urandom % 16),
            ($urandom % 2) ? lims[$urandom % 3] : 32'($urandom % 17),
            3'($urandom), {13'($urandom % 8), 3'($urandom)});
      case ($urandom % 3)
        0: o = $urandom;
        1: o = $urandom & 32'hFF;
        default: o = $urandom & 32'h1FFF;
      endcase
      xreq("R2-mix random", 2'($urandom), 1'($urandom), ($urandom % 4 == 0),
           3'($urandom), o, 2'($urandom));
    end
    idle_check();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule